// File: doc/BRIEF.md
# Fractional-Divider Asynchronous Serial Transmitter

This block sends characters on an asynchronous serial line. The bit period is set by a fixed-point clock divider that has a fractional part, so the line can reach bit rates that are not a whole fraction of the system clock. One 32-bit setup word holds both the divider and the character length. The block takes a parallel word through a valid/ready handshake and sends it as a low start bit, the data bits least significant first, and one high stop bit.

Bit edges come from a running target, kept in 1/64ths of a clock, that grows by the divider once per bit. A bit ends when the clock count since the start of the character reaches the integer part of that target. The target is cleared for each new character, so rounding error never carries from one character into the next. The setup word is latched when a character is accepted. Software waits for `busy` to fall before it changes the setup word.

Top module: `frac_uart_tx`

## Requirements
- R1: After reset, `tx_line` is 1, `busy` is 0 and `in_ready` is 1. Whenever `busy` is 0, `tx_line` is 1.
- R2: A word is accepted only on a rising clock edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 until the whole character has been sent. Data or valid pulses presented while `in_ready` is 0 are ignored.
- R3: Each character is sent as one start bit at 0, then `cfg[4:0]+1` data bits with bit 0 first, then one stop bit at 1. A value of 7 gives 8-bit characters, and up to 32 data bits are possible.
- R4: When `cfg[31:16]` is 1024 or more, the divider is the integer `cfg[31:16]`, `cfg[15:10]` is ignored, and every bit lasts exactly `cfg[31:16]` clocks.
- R5: When `cfg[31:16]` is below 1024, the divider is S = `cfg[31:16]` + `cfg[15:10]`/64. Bit k of a character (start bit is k=0) covers clocks floor(k*S) to floor((k+1)*S)-1, counted from the first clock of the start bit.
- R6: The fractional timing restarts with every character. Two characters with the same setup word and data have identical waveforms relative to their start bits, even when they are sent back to back.
- R7: The transmitter works correctly with a divider of 2.0, giving 2 clocks per bit.
- R8: `busy` rises on the clock edge that accepts a word. The start bit appears on `tx_line` on that same edge. `busy` falls on the edge that ends the stop bit, and `in_ready` is the inverse of `busy`.
- R9: The setup word is sampled only on the accepting edge. Changes to `cfg` during a character do not affect it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg | input | 32 | Setup word: integer divider [31:16], fraction [15:10], length minus one [4:0] |
| in_data | input | 32 | Character data, bit 0 sent first |
| in_valid | input | 1 | Data word is offered |
| in_ready | output | 1 | Transmitter can take a word |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | A character is being sent |

## Verification
After an accepting edge E, `tx_line` and `busy` change on E itself. The bench therefore takes its first sample at the falling edge right after E and counts that sample as clock 0 of the start bit. From there it samples at every falling edge through the expected length floor((N+2)*S). It compares each sample with the bit index that R5 gives for that clock, so an edge that arrives one clock early or late is caught. One falling edge after the last clock, the bench expects `busy` at 0 and the line high. In the back-to-back case it expects the next start bit one clock after that.

// File: rtl/frac_uart_tx.sv
module frac_uart_tx #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 6,
  parameter int LEN_W  = 5,
  parameter int INT_MODE_MIN = 1024
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          cfg,
  input  logic [(1<<LEN_W)-1:0] in_data,
  input  logic                 in_valid,
  output logic                 in_ready,
  output logic                 tx_line,
  output logic                 busy
);
  localparam int DATA_W = 1 << LEN_W;
  localparam int STEP_W = DIV_W + FRAC_W;
  localparam int ACC_W  = STEP_W + LEN_W + 1;
  localparam int CNT_W  = ACC_W - FRAC_W;

  logic [DIV_W-1:0]  div_int;
  logic [FRAC_W-1:0] div_frac;
  logic [STEP_W-1:0] step_new, step_q;
  logic [LEN_W:0]    nbits_q, idx_q;
  logic [ACC_W-1:0]  tgt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] shreg_q;
  logic              accept, bit_end;

  assign div_int  = cfg[31:32-DIV_W];
  assign div_frac = (div_int >= DIV_W'(INT_MODE_MIN)) ? '0 : cfg[31-DIV_W:32-DIV_W-FRAC_W];
  assign step_new = {div_int, div_frac};
  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;
  assign bit_end  = busy && ((cnt_q + 1'b1) >= tgt_q[ACC_W-1:FRAC_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      tx_line <= 1'b1;
      step_q  <= '0;
      nbits_q <= '0;
      idx_q   <= '0;
      tgt_q   <= '0;
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      tx_line <= 1'b0;
      step_q  <= step_new;
      nbits_q <= {1'b0, cfg[LEN_W-1:0]} + 1'b1;
      idx_q   <= '0;
      tgt_q   <= ACC_W'(step_new);
      cnt_q   <= '0;
      shreg_q <= in_data;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
      if (bit_end) begin
        idx_q <= idx_q + 1'b1;
        tgt_q <= tgt_q + ACC_W'(step_q);
        if (idx_q < nbits_q) begin
          tx_line <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
        end else if (idx_q == nbits_q) begin
          tx_line <= 1'b1;
        end else begin
          busy <= 1'b0;
        end
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);
  assert_start_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !tx_line && !in_ready));
  assert_min_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && step_q >= STEP_W'(2 << FRAC_W)) |=> !bit_end);
  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(step_q) && $stable(nbits_q));
  assert_stop_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> tx_line);
endmodule

// File: tb/test_frac_uart_tx.sv
module test_frac_uart_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic [31:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready, tx_line, busy;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  frac_uart_tx i_frac_uart_tx (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .in_data(in_data),
    .in_valid(in_valid), .in_ready(in_ready), .tx_line(tx_line), .busy(busy)
  );

  always #2.5 clk = ~clk;

  function automatic longint step64(logic [31:0] c);
    if (c[31:16] >= 16'd1024) return longint'(c[31:16]) * 64;
    return longint'(c[31:16]) * 64 + longint'(c[15:10]);
  endfunction

  function automatic int total_clks(logic [31:0] c);
    return int'((longint'(c[4:0]) + 3) * step64(c) / 64);
  endfunction

  function automatic logic exp_line(logic [31:0] c, logic [31:0] d, int j);
    int k = 0;
    int nb = int'(c[4:0]) + 1;
    while ((longint'(k) + 1) * step64(c) / 64 <= j) k++;
    if (k == 0) return 1'b0;
    if (k <= nb) return d[k-1];
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic offer(input logic [31:0] c, input logic [31:0] d);
    @(negedge clk);
    cfg = c; in_data = d; in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // starts right after the accepting edge; ends at the negedge after the stop bit
  task automatic check_char(input logic [31:0] c, input logic [31:0] d, input string req);
    int tot = total_clks(c);
    int bad = -1;
    logic act = 1'b0, ex = 1'b0;
    bit hold_ok = 1'b1;
    for (int j = 0; j < tot; j++) begin
      @(negedge clk);
      if (!busy || in_ready) hold_ok = 1'b0;
      if (bad < 0 && tx_line !== exp_line(c, d, j)) begin
        bad = j; act = tx_line; ex = exp_line(c, d, j);
      end
    end
    check(bad < 0, req, $sformatf("waveform clock %0d", bad), act, ex);
    check(hold_ok, "R8", "busy high and ready low during character", 0, 1);
    @(negedge clk);
    check(!busy && in_ready && tx_line, "R8", "idle after stop bit",
          {busy, in_ready, tx_line}, 3'b011);
  endtask

  task automatic t_reset;
    check(tx_line === 1'b1 && busy === 1'b0 && in_ready === 1'b1, "R1",
          "reset state", {tx_line, busy, in_ready}, 3'b101);
  endtask

  task automatic t_div2_8n1;
    logic [31:0] c = {16'd2, 6'd0, 5'd0, 5'd7};
    offer(c, 32'h0000_00A5);
    check(busy === 1'b1, "R8", "busy right after accept", busy, 1);
    check(total_clks(c) == 20, "R7", "8N1 at divider 2 is 20 clocks", total_clks(c), 20);
    check_char(c, 32'h0000_00A5, "R7");
  endtask

  task automatic t_frac_8bit;
    logic [31:0] c = {16'd3, 6'd21, 5'd0, 5'd7};
    offer(c, 32'h0000_0036);
    check_char(c, 32'h0000_0036, "R5");
  endtask

  task automatic t_len5;
    logic [31:0] c = {16'd5, 6'd32, 5'd0, 5'd4};
    offer(c, 32'h0000_0013);
    check_char(c, 32'h0000_0013, "R3");
  endtask

  task automatic t_len32;
    logic [31:0] c = {16'd2, 6'd16, 5'd0, 5'd31};
    offer(c, 32'hC3A5_0F71);
    check_char(c, 32'hC3A5_0F71, "R3");
  endtask

  task automatic t_int_mode;
    logic [31:0] c = {16'd1024, 6'd63, 5'd0, 5'd4};
    offer(c, 32'h0000_0019);
    check(total_clks(c) == 7 * 1024, "R4", "integer mode length", total_clks(c), 7168);
    check_char(c, 32'h0000_0019, "R4");
  endtask

  task automatic t_back_to_back;
    logic [31:0] c = {16'd2, 6'd43, 5'd0, 5'd7};
    offer(c, 32'h0000_005C);
    in_valid = 1'b1;
    check_char(c, 32'h0000_005C, "R6");
    @(posedge clk);
    #1 in_valid = 1'b0;
    check_char(c, 32'h0000_005C, "R6");
  endtask

  task automatic t_ignore_while_busy;
    logic [31:0] c = {16'd4, 6'd10, 5'd0, 5'd7};
    bit stray = 1'b0;
    offer(c, 32'h0000_00E1);
    fork
      check_char(c, 32'h0000_00E1, "R9");
      begin
        cfg = {16'd2, 6'd0, 5'd0, 5'd3};
        in_data = 32'h0000_0000;
        in_valid = 1'b1;
        repeat (8) @(negedge clk);
        in_valid = 1'b0;
      end
    join
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (!tx_line || busy) stray = 1'b1;
    end
    check(!stray, "R2", "word offered while busy was not sent", stray, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_div2_8n1();
        t_frac_8bit();
        t_len5();
        t_len32();
        t_int_mode();
        t_back_to_back();
        t_ignore_while_busy();
        done = 1'b1;
      end
      begin
        repeat (150000) @(posedge clk);
        if (!done) check(1'b0, "R8", "watchdog expired", 0, 1);
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule